// File: doc/BRIEF.md
# Sparsified Token Readout Serializer

This block sits behind a 128-channel shadow register. The register holds one digitised event, a 7-bit pulse height per channel and a flag per channel that marks it as above threshold. When a readout token arrives, the block picks the channels to send and puts them on a single serial data line. It then hands the token on to the next chip in the daisy chain. A ring of priority logic walks the pending channels from the lowest number upward. Each contiguous run of selected channels goes out as one group: one address, then the pulse heights for the whole run.

Three selection policies are available. The first sends the flagged channels only. The second adds the immediate neighbours of each flagged channel, and never looks past either end of the chip. The third sends every channel. If the event buffer has ever overflowed, or a token comes in while no event is waiting, the block sends a short fixed error packet in place of data. That packet carries the 4-bit chip identity, which is strapped on pins.

Top module: `strip_sparse_readout`

## Requirements
- R1: With `mode_in` = 2'b00, exactly the channels whose `valid_in` bit is 1 are sent.
- R2: With `mode_in` = 2'b01, channel i is sent when `valid_in` is set on channel i, on channel i-1 or on channel i+1. Only channels 0..127 count, so channel 0 has no lower neighbour and channel 127 has no upper neighbour.
- R3: With `mode_in` = 2'b10 or 2'b11, all 128 channels are sent as a single group.
- R4: Each group is made of these fields, in order:
  - the bits 0,1;
  - an 11-bit address: the 4-bit `chip_id` followed by the 7-bit number of the first channel in the group;
  - for each channel in the group, a 1 followed by its 7-bit pulse height;
  - a closing 1.

  A maximal run of consecutive selected channels forms one group, and groups go out in ascending channel order. Channel i's pulse height is `ph_in[7*i+6 : 7*i]`.
- R5: After a one-cycle pulse on `overflow_in`, every later token produces only the packet 0,0,1,`chip_id`(4),0,0,0,1, whatever `event_ready` says. This continues until reset.
- R6: With no overflow recorded and `event_ready` low when the token is sampled, the packet sent is 0,0,1,`chip_id`(4),1,0,1,1.
- R7: Bits leave every field MSB first, one per clock, with no gaps between fields or groups. The first bit is on `data_out` in the cycle after the clock edge that samples `token_in`. `data_out` is 0 whenever nothing is being sent.
- R8: `token_out` is a one-cycle pulse in the cycle right after the last bit. If an event is pending but no channel is selected, no bits are sent and `token_out` pulses in the cycle after the token is sampled.
- R9: A `token_in` pulse that arrives while a readout is in progress is ignored, and the stream under way is unchanged.
- R10: During and after reset, `data_out`, `token_out` and `busy` are 0, and any recorded overflow is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| token_in | input | 1 | Readout token from the previous chip, one-cycle pulse |
| event_ready | input | 1 | The shadow register holds an event for readout |
| overflow_in | input | 1 | Pulse: the event buffer has overflowed |
| mode_in | input | 2 | Selection policy (00 flagged, 01 flagged plus neighbours, 1x all) |
| chip_id | input | 4 | Strapped chip identity |
| valid_in | input | 128 | Per-channel above-threshold flags |
| ph_in | input | 896 | Pulse heights, 7 bits per channel, channel 0 in the low bits |
| data_out | output | 1 | Serial data, MSB first |
| token_out | output | 1 | Token to the next chip, one-cycle pulse |
| busy | output | 1 | A readout is in progress |

## Verification
The assertions take for granted that `ph_in` stays still for as long as `busy` is high. They also assume that `overflow_in` and `token_in` never pulse in the same cycle, and that the selection mode and flags are settled when the token is sampled. The bench changes flags, pulse heights, mode and chip identity only while the block is idle. It raises overflow on its own, several idle cycles before the next token. The only token sent during a readout is the deliberate one used to test that such tokens are ignored.

// File: rtl/sro_pkg.sv
// Shared types and fixed field codes for the sparsified readout serializer.
// Assumes: field codes are fixed by the downstream data format.
package sro_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_CHN,
        ST_TRL,
        ST_ERR
    } rd_state_t;

    localparam logic [1:0] MRK_HIT    = 2'b01;
    localparam logic [1:0] MRK_ERR    = 2'b00;
    localparam logic [2:0] ERR_OVF    = 3'b000;
    localparam logic [2:0] ERR_NODATA = 3'b101;
endpackage

// File: rtl/sro_select.sv
// Channel selection mask.
// Turns the per-channel above-threshold flags into the set of channels to
// send under the chosen policy. Neighbours stop at the chip edges.
// Assumes: mode 00 flagged only, 01 flagged plus neighbours, 1x all.
module sro_select #(
    parameter int NCH = 128
) (
    input  logic [1:0]     mode,
    input  logic [NCH-1:0] valid,
    output logic [NCH-1:0] sel
);
    logic [NCH-1:0] widened;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic lower, upper;
        if (i == 0) begin : g_lo_edge
            assign lower = 1'b0;
        end else begin : g_lo
            assign lower = valid[i-1];
        end
        if (i == NCH-1) begin : g_hi_edge
            assign upper = 1'b0;
        end else begin : g_hi
            assign upper = valid[i+1];
        end
        assign widened[i] = valid[i] | lower | upper;
    end

    // Pick the mask for the requested policy.
    always_comb begin
        case (mode)
            2'b00:   sel = valid;
            2'b01:   sel = widened;
            default: sel = '1;
        endcase
    end
endmodule

// File: rtl/sro_first_set.sv
// Lowest-index set bit finder, used as the channel search ring.
// Assumes: purely combinational, index valid only when found is high.
module sro_first_set #(
    parameter int N  = 128,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // Scan downward so that the lowest set bit wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int k = N-1; k >= 0; k--) begin
            if (vec[k]) begin
                idx   = IW'(k);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sro_shifter.sv
// Piece shifter: loads a right-aligned field of up to W bits and sends it
// MSB first, one bit per clock; last is high while the final bit is out.
// Assumes: a new piece is loaded in the cycle last is high for gapless output.
module sro_shifter #(
    parameter int W  = 13,
    localparam int LW = $clog2(W+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_bits,
    input  logic [LW-1:0] load_len,
    output logic          bit_out,
    output logic          last
);
    logic [W-1:0]  sh;
    logic [LW-1:0] cnt;

    // Left-align on load, otherwise shift out and count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= load_bits << (LW'(W) - load_len);
            cnt <= load_len - 1'b1;
        end else begin
            sh <= sh << 1;
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign bit_out = sh[W-1];
    assign last    = (cnt == '0);

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0 && int'(load_len) <= W)) else $error("bad piece length"); // R7
endmodule

// File: rtl/strip_sparse_readout.sv
// Token-driven sparsified serial readout of a channel shadow register.
// On a token: sends an error packet, nothing, or hit groups in ascending
// channel order, then pulses token_out in the cycle after the last bit.
// Assumes: ph_in stays stable while busy; tokens arrive as single-cycle pulses.
module strip_sparse_readout #(
    parameter int NCH  = 128,
    parameter int PH_W = 7,
    parameter int ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                token_in,
    input  logic                event_ready,
    input  logic                overflow_in,
    input  logic [1:0]          mode_in,
    input  logic [ID_W-1:0]     chip_id,
    input  logic [NCH-1:0]      valid_in,
    input  logic [NCH*PH_W-1:0] ph_in,
    output logic                data_out,
    output logic                token_out,
    output logic                busy
);
    import sro_pkg::*;

    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = ID_W + CH_W;
    localparam int HDR_W  = 2 + ADDR_W;
    localparam int CHN_W  = 1 + PH_W;
    localparam int ERR_W  = 2 + 1 + ID_W + 3 + 1;
    localparam int TMP_W  = (HDR_W > ERR_W) ? HDR_W : ERR_W;
    localparam int SH_W   = (TMP_W > CHN_W) ? TMP_W : CHN_W;
    localparam int LEN_W  = $clog2(SH_W + 1);

    rd_state_t       state, nxt;
    logic [NCH-1:0]  pend, sel_mask, scan_vec;
    logic [CH_W-1:0] cur, cur_d, cur_nx, first_idx, clr_idx, ph_idx;
    logic            first_found, ovf_q, token_q, tok_d, clr, pend_ld, nxt_ok;
    logic            sh_load, sh_bit, sh_last;
    logic [SH_W-1:0] sh_bits, hdr_piece, chn_piece;
    logic [LEN_W-1:0] sh_len;
    logic [PH_W-1:0] ph_sel;

    sro_select #(.NCH(NCH)) u_select (
        .mode  (mode_in),
        .valid (valid_in),
        .sel   (sel_mask)
    );

    // Search the fresh mask at token time, the pending set otherwise.
    assign scan_vec = (state == ST_IDLE) ? sel_mask : pend;

    sro_first_set #(.N(NCH)) u_first (
        .vec   (scan_vec),
        .idx   (first_idx),
        .found (first_found)
    );

    sro_shifter #(.W(SH_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_bits (sh_bits),
        .load_len  (sh_len),
        .bit_out   (sh_bit),
        .last      (sh_last)
    );

    assign cur_nx    = cur + 1'b1;
    assign nxt_ok    = (cur != CH_W'(NCH-1)) && pend[cur_nx];
    assign ph_idx    = (state == ST_HDR) ? cur : cur_nx;
    assign ph_sel    = ph_in[int'(ph_idx)*PH_W +: PH_W];
    assign hdr_piece = SH_W'({MRK_HIT, chip_id, first_idx});
    assign chn_piece = SH_W'({1'b1, ph_sel});

    // Sequencing: choose the next piece to load and the next state.
    always_comb begin
        nxt     = state;
        sh_load = 1'b0;
        sh_bits = '0;
        sh_len  = '0;
        cur_d   = cur;
        tok_d   = 1'b0;
        clr     = 1'b0;
        clr_idx = cur;
        pend_ld = 1'b0;
        case (state)
            ST_IDLE: begin
                if (token_in) begin
                    if (ovf_q || !event_ready) begin
                        sh_load = 1'b1;
                        sh_bits = SH_W'({MRK_ERR, 1'b1, chip_id,
                                         ovf_q ? ERR_OVF : ERR_NODATA, 1'b1});
                        sh_len  = LEN_W'(ERR_W);
                        nxt     = ST_ERR;
                    end else if (first_found) begin
                        pend_ld = 1'b1;
                        sh_load = 1'b1;
                        sh_bits = hdr_piece;
                        sh_len  = LEN_W'(HDR_W);
                        cur_d   = first_idx;
                        nxt     = ST_HDR;
                    end else begin
                        tok_d = 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (sh_last) begin
                    sh_load = 1'b1;
                    sh_bits = chn_piece;
                    sh_len  = LEN_W'(CHN_W);
                    clr     = 1'b1;
                    clr_idx = cur;
                    nxt     = ST_CHN;
                end
            end
            ST_CHN: begin
                if (sh_last) begin
                    sh_load = 1'b1;
                    if (nxt_ok) begin
                        sh_bits = chn_piece;
                        sh_len  = LEN_W'(CHN_W);
                        clr     = 1'b1;
                        clr_idx = cur_nx;
                        cur_d   = cur_nx;
                    end else begin
                        sh_bits = SH_W'(1'b1);
                        sh_len  = LEN_W'(1);
                        nxt     = ST_TRL;
                    end
                end
            end
            ST_TRL: begin
                if (sh_last) begin
                    if (first_found) begin
                        sh_load = 1'b1;
                        sh_bits = hdr_piece;
                        sh_len  = LEN_W'(HDR_W);
                        cur_d   = first_idx;
                        nxt     = ST_HDR;
                    end else begin
                        tok_d = 1'b1;
                        nxt   = ST_IDLE;
                    end
                end
            end
            ST_ERR: begin
                if (sh_last) begin
                    tok_d = 1'b1;
                    nxt   = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, pending set, sticky overflow and token register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur     <= '0;
            pend    <= '0;
            ovf_q   <= 1'b0;
            token_q <= 1'b0;
        end else begin
            state   <= nxt;
            cur     <= cur_d;
            token_q <= tok_d;
            if (overflow_in) ovf_q <= 1'b1;
            if (pend_ld) pend <= sel_mask;
            else if (clr) pend[clr_idx] <= 1'b0;
        end
    end

    assign data_out  = sh_bit;
    assign token_out = token_q;
    assign busy      = (state != ST_IDLE);

    AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out) else $error("token held"); // R8
    AST_TOKEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> !busy) else $error("token while busy"); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !data_out) else $error("data while idle"); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q) else $error("overflow lost"); // R5
    AST_PEND_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((pend & ~$past(pend)) == '0)) else $error("pending grew"); // R4
    AST_FIRST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && first_found) |-> (scan_vec[first_idx] &&
            ((scan_vec & ~({NCH{1'b1}} << first_idx)) == '0))) else $error("search order"); // R4
    AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ph_in)) else $error("pulse heights moved"); // R4
endmodule

// File: tb/strip_sparse_readout_bench.sv
module strip_sparse_readout_bench;
    localparam int NCH  = 128;
    localparam int PH_W = 7;
    localparam int ID_W = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                token_in = 1'b0;
    logic                event_ready = 1'b0;
    logic                overflow_in = 1'b0;
    logic [1:0]          mode_in = 2'b00;
    logic [ID_W-1:0]     chip_id = '0;
    logic [NCH-1:0]      valid_in = '0;
    logic [NCH*PH_W-1:0] ph_in = '0;
    logic                data_out, token_out, busy;

    int n_checks = 0;
    int n_err = 0;
    bit exp_bits [0:2047];
    bit got_bits [0:2047];
    int exp_n, got_n;
    logic [PH_W-1:0] ph_arr [NCH];

    always #5 clk = ~clk;

    strip_sparse_readout #(.NCH(NCH), .PH_W(PH_W), .ID_W(ID_W)) u_strip_sparse_readout (
        .clk(clk), .rst_n(rst_n), .token_in(token_in), .event_ready(event_ready),
        .overflow_in(overflow_in), .mode_in(mode_in), .chip_id(chip_id),
        .valid_in(valid_in), .ph_in(ph_in), .data_out(data_out),
        .token_out(token_out), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_val(input int v, input int w);
        for (int k = w-1; k >= 0; k--) begin
            exp_bits[exp_n] = v[k];
            exp_n++;
        end
    endtask

    // Expected stream from the requirements (R1..R6).
    task automatic build_expected(input logic [1:0] m, input bit ovf, input bit rdy);
        bit s [NCH];
        int i;
        exp_n = 0;
        if (ovf || !rdy) begin
            push_val(1, 3);
            push_val(int'(chip_id), ID_W);
            push_val(ovf ? 0 : 5, 3);
            push_val(1, 1);
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m[1]) s[c] = 1'b1;
                else begin
                    s[c] = valid_in[c];
                    if (m == 2'b01) begin
                        if (c > 0 && valid_in[c-1]) s[c] = 1'b1;
                        if (c < NCH-1 && valid_in[c+1]) s[c] = 1'b1;
                    end
                end
            end
            i = 0;
            while (i < NCH) begin
                if (s[i]) begin
                    push_val(1, 2);
                    push_val(int'(chip_id), ID_W);
                    push_val(i, 7);
                    while (i < NCH && s[i]) begin
                        push_val(1, 1);
                        push_val(int'(ph_arr[i]), PH_W);
                        i++;
                    end
                    push_val(1, 1);
                end else i++;
            end
        end
    endtask

    // Send a token, capture the stream up to token_out, compare (R7, R8, R9).
    task automatic run_token(input string tag, input int extra_at);
        bit tok_seen;
        int k;
        int bad;
        @(negedge clk) token_in = 1'b1;
        @(negedge clk) token_in = 1'b0;
        got_n = 0; tok_seen = 1'b0; k = 0;
        while (!tok_seen && k < 1500) begin
            if (token_out) begin
                tok_seen = 1'b1;
                check(data_out == 1'b0, tag, "R7 data at token time", int'(data_out), 0);
            end else begin
                got_bits[got_n] = data_out;
                got_n++;
                k++;
                token_in = (k == extra_at);
                @(negedge clk);
            end
        end
        token_in = 1'b0;
        check(tok_seen, tag, "R8 token_out seen", int'(tok_seen), 1);
        @(negedge clk);
        check(token_out == 1'b0, tag, "R8 token_out one cycle", int'(token_out), 0);
        check(got_n == exp_n, tag, "R7/R8 bit count before token", got_n, exp_n);
        bad = -1;
        for (int b = 0; b < exp_n && b < got_n; b++)
            if (bad < 0 && got_bits[b] != exp_bits[b]) bad = b;
        check(bad < 0, tag, "R4 stream content, first bad bit index", bad, -1);
        repeat (2) @(negedge clk);
    endtask

    task automatic load_pattern(input int p);
        for (int c = 0; c < NCH; c++) begin
            case (p)
                0: valid_in[c] = 1'b0;
                1: valid_in[c] = 1'b1;
                2: valid_in[c] = (c == 0);
                3: valid_in[c] = (c == NCH-1);
                4: valid_in[c] = (c < 2) || (c >= NCH-2);
                5: valid_in[c] = (c % 3 == 0);
                6: valid_in[c] = (c % 2 == 1);
                7: valid_in[c] = (c == 2) || (c == NCH-3) || (c == 60);
                default: valid_in[c] = ($urandom % 5 == 0);
            endcase
            ph_arr[c] = PH_W'((c*29 + p*13 + 5) % 128);
            ph_in[c*PH_W +: PH_W] = ph_arr[c];
        end
        chip_id = ID_W'((p*7 + 3) % 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R8: got %0d expected %0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(data_out == 1'b0 && token_out == 1'b0 && busy == 1'b0, "R10",
              "outputs in reset", int'({data_out, token_out, busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(data_out == 1'b0 && token_out == 1'b0, "R10", "outputs after reset",
              int'({data_out, token_out}), 0);
        event_ready = 1'b1;

        // Sweep: R1 (mode 00), R2 (mode 01), R3 (modes 10, 11)
        for (int p = 0; p < 12; p++) begin
            load_pattern(p);
            for (int m = 0; m < 4; m++) begin
                mode_in = 2'(m);
                build_expected(2'(m), 1'b0, 1'b1);
                run_token(m == 0 ? "R1" : (m == 1 ? "R2" : "R3"), -1);
            end
        end

        // R9: token during an all-channel readout is ignored
        load_pattern(5);
        mode_in = 2'b10;
        build_expected(2'b10, 1'b0, 1'b1);
        run_token("R9", 20);

        // R6: token with no event pending
        event_ready = 1'b0;
        chip_id = 4'hA;
        build_expected(2'b00, 1'b0, 1'b0);
        run_token("R6", -1);

        // R5: overflow is sticky and beats a pending event
        @(negedge clk) overflow_in = 1'b1;
        @(negedge clk) overflow_in = 1'b0;
        repeat (3) @(negedge clk);
        event_ready = 1'b1;
        mode_in = 2'b00;
        chip_id = 4'h6;
        build_expected(2'b00, 1'b1, 1'b1);
        run_token("R5", -1);
        event_ready = 1'b0;
        build_expected(2'b00, 1'b1, 1'b0);
        run_token("R5", -1);
        event_ready = 1'b1;
        build_expected(2'b00, 1'b1, 1'b1);
        run_token("R5", -1);

        // R10: reset clears the overflow record
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && data_out == 1'b0, "R10", "idle in reset", int'({busy, data_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        event_ready = 1'b0;
        build_expected(2'b00, 1'b0, 1'b0);
        run_token("R10", -1);
        event_ready = 1'b1;
        load_pattern(7);
        mode_in = 2'b01;
        build_expected(2'b01, 1'b0, 1'b1);
        run_token("R10", -1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule